// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the PHY-side endpoint of a clause-22 style serial management bus. It samples the serial data line on every rising edge of the management clock. It hunts for a preamble of ones followed by the `01` start pattern, then collects a 2-bit opcode, a 5-bit PHY address and a 5-bit register address. When the opcode is a read and the PHY address matches, it turns the line around and shifts out a 16-bit register, most-significant bit first. When the opcode is a write and the address matches, it lets the master own the turnaround and captures 16 data bits into the addressed register.

A register file of `NUM_REGS` 16-bit words backs the frames, and all of its words clear to zero at reset. Addresses at or above `NUM_REGS` are unimplemented. The PHY address comes from a strap input that is captured while reset is held. The bidirectional pin is modelled as a separate input, output and output enable, so the pad and pull-up stay outside the block.

The frame controller has these states:
- `ST_HUNT` counts ones and leaves on a 0 once the count is full.
- `ST_START` expects the 1 of the start pattern.
- `ST_OPCODE`, `ST_PHYAD` and `ST_REGAD` collect the header fields.
- `ST_TA_RD1` and `ST_TA_RD2` are the read turnaround, with the line released and then driven to 0.
- `ST_RD_DATA` shifts out the read data.
- `ST_TA_WR` consumes the write turnaround.
- `ST_WR_DATA` collects the write data.

The controller moves through these transitions:
- HUNT→START when a 0 follows a full preamble.
- START→OPCODE on a 1, or START→HUNT on a 0.
- OPCODE→PHYAD→REGAD after each field is complete.
- REGAD→TA_RD1 on a matching read, REGAD→TA_WR on a matching write, or REGAD→HUNT otherwise.
- TA_RD1→TA_RD2→RD_DATA.
- TA_WR→WR_DATA.
- RD_DATA→HUNT and WR_DATA→HUNT after the sixteenth data bit.

Top module: `mdio_slave`

## Requirements
- R1: A frame is recognised only after at least `PREAMBLE_LEN` (default 32) consecutive 1 bits followed by the start bits 0 then 1. After a preamble that is one bit short, the frame causes no drive and no register change.
- R2: Opcode 2'b10 is a read and 2'b01 is a write. Opcodes 2'b00 and 2'b11 cause no drive and no register change.
- R3: The slave responds only when the PHY address field equals the strap value captured while `rst_n` was low. Changing the strap after reset has no effect.
- R4: On a responding read, `mdio_oe` is low during the first turnaround bit. During the second turnaround bit the slave drives 0.
- R5: On any write frame, `mdio_oe` stays low through the turnaround and all data bits.
- R6: On a responding read, the 16 data bits follow the turnaround most-significant bit first. The slave releases the line in the bit after the last data bit.
- R7: On a responding write to an implemented address, the 16 bits that follow the turnaround, first bit as bit 15, are stored in the addressed register.
- R8: A read of an address at or above `NUM_REGS` returns 16'hFFFF.
- R9: A write to an address at or above `NUM_REGS` leaves every register unchanged.
- R10: `mdio_oe` is low during reset and whenever no read turnaround or read data bit is in progress.
- R11: A new frame's preamble may begin in the bit right after the previous frame's last data bit.
- R12: After reset, every implemented register reads 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled and the state advances on its rising edge |
| rst_n | input | 1 | Active-low reset; the PHY address strap is captured while low |
| phy_addr_strap | input | 5 | PHY address strap value |
| mdio_in | input | 1 | Sampled level of the management data line |
| mdio_out | output | 1 | Value driven on the line while the output is enabled |
| mdio_oe | output | 1 | Output enable for the management data line |

## Verification
The bench builds the block with `NUM_REGS` = 8 and `PREAMBLE_LEN` = 32. With these values, 24 of the 32 register addresses are unimplemented, so random traffic hits unimplemented reads and discarded writes often. A 31-bit preamble falls exactly one short of the threshold. Every frame starts in the bit right after the previous one ends, which exercises back-to-back acceptance after both reads and writes. Random frames mix matching and foreign PHY addresses, along with valid and invalid opcodes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;
    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(DATA_W);

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TA_RD1,
        ST_TA_RD2,
        ST_RD_DATA,
        ST_TA_WR,
        ST_WR_DATA
    } frame_state_t;

endpackage

// File: rtl/mdio_addr_latch.sv
module mdio_addr_latch
    import mdio_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [PHY_AW-1:0] strap,
    output logic [PHY_AW-1:0] my_addr
);

    // Captured on every clock while reset is held, frozen afterwards.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            my_addr <= strap;
        end
    end

    a_r3_addr_frozen: assert property (@(posedge mdc) disable iff (!rst_n)
        $past(rst_n) |-> $stable(my_addr));

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_addr == REG_AW'(i)) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end

    // Unimplemented addresses fall through to all ones.
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == REG_AW'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_guard
        // R9: only a write aimed at this word may change it
        a_r9_untouched: assert property (@(posedge mdc) disable iff (!rst_n)
            !(wr_en && wr_addr == REG_AW'(g)) |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [PHY_AW-1:0] my_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_oe,
    output logic              mdio_out
);

    localparam int PRE_W = $clog2(PREAMBLE_LEN + 1);
    localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PREAMBLE_LEN);
    localparam int HDR_W = 2 + PHY_AW + REG_AW;

    frame_state_t state, state_n;
    logic [PRE_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [HDR_W-2:0]  hdr_q;
    logic [DATA_W-1:0] shreg;
    logic [REG_AW-1:0] addr_q;

    logic [HDR_W-1:0]  hdr_full;
    logic [1:0]        op_f;
    logic [PHY_AW-1:0] phy_f;
    logic [REG_AW-1:0] reg_f;
    logic              last_bit;
    logic              hit_rd;
    logic              hit_wr;

    assign hdr_full = {hdr_q, mdio_in};
    assign op_f     = hdr_full[HDR_W-1 -: 2];
    assign phy_f    = hdr_full[REG_AW +: PHY_AW];
    assign reg_f    = hdr_full[REG_AW-1:0];
    assign last_bit = (bit_cnt == '0);
    assign hit_rd   = (op_f == OPC_READ)  && (phy_f == my_addr);
    assign hit_wr   = (op_f == OPC_WRITE) && (phy_f == my_addr);

    function automatic logic [CNT_W-1:0] load_for(frame_state_t s);
        case (s)
            ST_OPCODE:  return CNT_W'(1);
            ST_PHYAD:   return CNT_W'(PHY_AW - 1);
            ST_REGAD:   return CNT_W'(REG_AW - 1);
            ST_TA_WR:   return CNT_W'(1);
            ST_RD_DATA: return CNT_W'(DATA_W - 1);
            ST_WR_DATA: return CNT_W'(DATA_W - 1);
            default:    return '0;
        endcase
    endfunction

    // Next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT:    if (!mdio_in && pre_cnt == PRE_FULL) state_n = ST_START;
            ST_START:   state_n = mdio_in ? ST_OPCODE : ST_HUNT;
            ST_OPCODE:  if (last_bit) state_n = ST_PHYAD;
            ST_PHYAD:   if (last_bit) state_n = ST_REGAD;
            ST_REGAD: begin
                if (last_bit) begin
                    if (hit_rd)      state_n = ST_TA_RD1;
                    else if (hit_wr) state_n = ST_TA_WR;
                    else             state_n = ST_HUNT;
                end
            end
            ST_TA_RD1:  state_n = ST_TA_RD2;
            ST_TA_RD2:  state_n = ST_RD_DATA;
            ST_RD_DATA: if (last_bit) state_n = ST_HUNT;
            ST_TA_WR:   if (last_bit) state_n = ST_WR_DATA;
            ST_WR_DATA: if (last_bit) state_n = ST_HUNT;
            default:    state_n = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_n;
    end

    // Counters and shifters
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            bit_cnt <= '0;
            hdr_q   <= '0;
            shreg   <= '0;
            addr_q  <= '0;
        end else begin
            if (state == ST_HUNT && mdio_in) begin
                if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
            end else begin
                pre_cnt <= '0;
            end

            if (state_n != state) bit_cnt <= load_for(state_n);
            else if (!last_bit)   bit_cnt <= bit_cnt - 1'b1;

            if (state == ST_OPCODE || state == ST_PHYAD || state == ST_REGAD) begin
                hdr_q <= hdr_full[HDR_W-2:0];
            end

            if (state == ST_REGAD && last_bit) addr_q <= reg_f;

            unique case (state)
                ST_TA_RD1:  shreg <= rd_data;
                ST_RD_DATA: shreg <= {shreg[DATA_W-2:0], 1'b0};
                ST_WR_DATA: shreg <= {shreg[DATA_W-2:0], mdio_in};
                default:    shreg <= shreg;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_addr = addr_q;
        wr_en    = (state == ST_WR_DATA) && last_bit;
        wr_data  = {shreg[DATA_W-2:0], mdio_in};
        mdio_oe  = (state == ST_TA_RD2) || (state == ST_RD_DATA);
        mdio_out = (state == ST_RD_DATA) && shreg[DATA_W-1];
    end

    // R4: the first bit the slave drives is the turnaround zero
    a_r4_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R6: the driven window is one turnaround bit plus the data field
    a_r6_drive_len: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> $past(mdio_oe, DATA_W + 1));

    // R10: after release, no drive can resume in the next bit
    a_r10_release_holds: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |=> !mdio_oe);

    // R5: a write frame never sees the slave driving
    a_r5_write_quiet: assert property (@(posedge mdc) disable iff (!rst_n)
        (state == ST_TA_WR || state == ST_WR_DATA) |-> !mdio_oe);

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
    import mdio_pkg::*;
#(
    parameter int NUM_REGS     = 8,
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [PHY_AW-1:0] phy_addr_strap,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe
);

    logic [PHY_AW-1:0] my_addr;
    logic [REG_AW-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    mdio_addr_latch u_addr (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .strap   (phy_addr_strap),
        .my_addr (my_addr)
    );

    mdio_frame_fsm #(
        .PREAMBLE_LEN (PREAMBLE_LEN)
    ) u_fsm (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .my_addr  (my_addr),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mdio_oe  (mdio_oe),
        .mdio_out (mdio_out)
    );

    mdio_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (reg_addr),
        .wr_data (wr_data),
        .rd_addr (reg_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sim_mdio_slave.sv
`timescale 1ns/1ps
module sim_mdio_slave;

    localparam int NR = 8;
    localparam logic [4:0] STRAP0 = 5'h0B;
    localparam logic [4:0] STRAP1 = 5'h1C;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap = STRAP0;
    logic       m_en = 1'b0;
    logic       m_bit = 1'b1;
    logic       mdio_out, mdio_oe, mdio_in;

    int checks = 0;
    int errors = 0;
    bit pend_rel = 0;
    bit done = 0;
    logic [15:0] model [32];

    always #2.5 mdc = ~mdc;

    // Pull-up: released line reads 1
    assign mdio_in = mdio_oe ? mdio_out : (m_en ? m_bit : 1'b1);

    mdio_slave #(.NUM_REGS(NR), .PREAMBLE_LEN(32)) u0 (
        .mdc(mdc), .rst_n(rst_n), .phy_addr_strap(strap),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] ra);
        return (ra < NR) ? model[ra] : 16'hFFFF;
    endfunction

    task automatic rel_check();
        if (pend_rel) begin
            chk(!mdio_oe, "R6 release after last data bit", {31'b0, mdio_oe}, 0);
            pend_rel = 0;
        end
    endtask

    task automatic drive(input logic b);
        @(negedge mdc);
        rel_check();
        m_en = 1'b1;
        m_bit = b;
    endtask

    task automatic release_bit();
        @(negedge mdc);
        rel_check();
        m_en = 1'b0;
    endtask

    task automatic frame(input int pre, input bit zero_first, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input string tag);
        bit resp;
        int bad;
        logic [15:0] got;
        logic [15:0] exp;
        resp = (pre >= 32) && (phy == STRAP0) && (op == 2'b10 || op == 2'b01);
        bad = 0;
        got = '0;
        if (zero_first) drive(1'b0);
        for (int i = 0; i < pre; i++) drive(1'b1);
        drive(1'b0);
        drive(1'b1);
        for (int i = 1; i >= 0; i--) drive(op[i]);
        for (int i = 4; i >= 0; i--) drive(phy[i]);
        for (int i = 4; i >= 0; i--) drive(ra[i]);
        if (op == 2'b10) begin
            release_bit();
            if (resp) chk(!mdio_oe, {tag, " R4 TA1 released"}, {31'b0, mdio_oe}, 0);
            else if (mdio_oe) bad++;
            release_bit();
            if (resp) chk(mdio_oe && !mdio_out, {tag, " R4 TA2 zero"}, {30'b0, mdio_oe, mdio_out}, 32'h2);
            else if (mdio_oe) bad++;
            for (int i = 0; i < 16; i++) begin
                release_bit();
                if (resp && !mdio_oe) bad++;
                if (!resp && mdio_oe) bad++;
                got = {got[14:0], mdio_in};
            end
            if (resp) begin
                exp = exp_read(ra);
                chk(got == exp && bad == 0, {tag, (ra < NR) ? " R6 read data" : " R8 unimpl read"}, {16'(bad), got}, {16'h0, exp});
                pend_rel = 1;
            end else begin
                chk(bad == 0, {tag, " no drive"}, bad, 0);
            end
        end else begin
            drive(1'b1);
            if (mdio_oe) bad++;
            drive(1'b0);
            if (mdio_oe) bad++;
            for (int i = 15; i >= 0; i--) begin
                drive(wd[i]);
                if (mdio_oe) bad++;
            end
            chk(bad == 0, {tag, (op == 2'b01) ? " R5 write quiet" : " R2 bad op quiet"}, bad, 0);
            if (resp && op == 2'b01 && ra < NR) model[ra] = wd;
        end
    endtask

    task automatic rd(input logic [4:0] ra, input string tag);
        frame(32, 1'b0, 2'b10, STRAP0, ra, 16'h0, tag);
    endtask

    task automatic wr(input logic [4:0] ra, input logic [15:0] d, input string tag);
        frame(32, 1'b0, 2'b01, STRAP0, ra, d, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        logic [1:0] op;
        logic [4:0] phy;
        for (int i = 0; i < 32; i++) model[i] = 16'h0;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge mdc);
        chk(!mdio_oe, "R10 oe low in reset", {31'b0, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge mdc);
        strap = STRAP1; // R3: post-reset change must be ignored
        chk(!mdio_oe, "R10 oe low idle", {31'b0, mdio_oe}, 0);

        for (int i = 0; i < NR; i++) rd(5'(i), "R12 reset value");

        wr(5'd3, 16'hA5C3, "R7");
        rd(5'd3, "R7 readback");
        wr(5'd7, 16'h8001, "R7");
        rd(5'd7, "R7 msb-first");
        rd(5'd0, "R7 neighbour untouched");

        rd(5'd20, "R8");
        rd(5'd31, "R8");
        wr(5'd20, 16'h1234, "R9");
        for (int i = 0; i < NR; i++) rd(5'(i), "R9 bank unchanged");
        rd(5'd20, "R9 still unimplemented");

        frame(32, 1'b0, 2'b01, STRAP1, 5'd1, 16'hDEAD, "R3 foreign write");
        rd(5'd1, "R3 foreign write dropped");
        frame(32, 1'b0, 2'b10, STRAP1, 5'd3, 16'h0, "R3 foreign read");

        frame(31, 1'b1, 2'b01, STRAP0, 5'd2, 16'hBEEF, "R1 short preamble write");
        rd(5'd2, "R1 short preamble dropped");
        frame(31, 1'b1, 2'b10, STRAP0, 5'd3, 16'h0, "R1 short preamble read");

        frame(32, 1'b0, 2'b00, STRAP0, 5'd4, 16'h7777, "R2 op00");
        frame(32, 1'b0, 2'b11, STRAP0, 5'd4, 16'h9999, "R2 op11");
        rd(5'd4, "R2 bad ops dropped");

        wr(5'd5, 16'h0F0F, "R11 back-to-back");
        rd(5'd5, "R11 read after write");
        rd(5'd5, "R11 read after read");
        wr(5'd6, 16'hC3C3, "R11 write after read");
        rd(5'd6, "R11 read after write");

        for (int n = 0; n < 80; n++) begin
            r = int'($urandom % 100);
            op = (r < 45) ? 2'b10 : (r < 90) ? 2'b01 : ((r & 1) ? 2'b11 : 2'b00);
            phy = ($urandom % 100 < 85) ? STRAP0 : 5'($urandom);
            frame(32 + int'($urandom % 4), 1'b0, op, phy, 5'($urandom), 16'($urandom), "R6/R7 random");
        end

        for (int i = 0; i < NR; i++) rd(5'(i), "R7 final bank");
        release_bit();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule